// File: doc/BRIEF.md
# Vertex Attribute Stream Fetch Engine

This block gathers per-vertex attribute data from as many as eight streams in system memory. It stores the data in a local attribute memory in a transposed layout: every row holds a single 32-bit attribute, and the columns of that row belong to successive vertices of a batch of up to sixteen. A shader then reads whole rows to process one attribute for all vertices at once. Software loads one descriptor per stream beforehand. A descriptor holds a base address, the number of bytes per vertex minus one, the byte distance between consecutive vertices, and two destination byte offsets, one for each shader type.

A batch starts with a one-cycle `start` pulse. The pulse carries three things: an 8-bit enable mask, a bit that chooses which of the two destination offsets applies, and the vertex count minus one. The engine first checks every enabled descriptor. A per-vertex size that is not a whole number of words is rejected. Otherwise the engine visits the enabled streams from the lowest index to the highest. For each stream it fetches every vertex's words through a single-outstanding request/valid read port and writes each word into the row and column where it belongs. A one-cycle `done` marks the point at which the whole batch is in the attribute memory. A registered read port lets the consumer fetch any row and column.

Top module: `attr_stream_fetch`

## Requirements
- R1: After a synchronous reset, `done`, `err` and `mem_req` are low.
- R2: The read address for word w of vertex v in stream s is base + v*stride + 4*w. The descriptor word packs the base in bits [31:0], size-minus-one in [39:32], stride in [47:40], shader-0 offset in [55:48] and shader-1 offset in [63:56]. Streams are visited in ascending index, vertices in ascending order, and words of a vertex in ascending address. A stride larger than the size leaves the bytes in between unread.
- R3: For each enabled stream, exactly (vcnt_m1+1) × (size+1)/4 reads are issued, and no other reads.
- R4: The word returned for word w of vertex v is written at row (offset/4 + w) modulo the row count and column v. It is readable one cycle after `rd_row`/`rd_col` are presented.
- R5: `shader_sel` = 0 takes the destination offset from descriptor bits [55:48], and `shader_sel` = 1 takes it from bits [63:56].
- R6: A stream whose mask bit is clear issues no reads and leaves the memory rows it would have written untouched. An all-zero mask completes with `done` and no reads.
- R7: If any enabled stream has size-minus-one with bits [1:0] not equal to 3, `err` pulses for exactly one cycle, in the cycle after `start`. In that case no read is issued and no `done` follows. An invalid descriptor on a disabled stream causes no error.
- R8: `done` pulses for exactly one cycle per accepted batch, after the last word of the batch has been written.
- R9: A `start` pulse that arrives while a batch is in progress is ignored.
- R10: `mem_req` is a one-cycle pulse, and no new request is issued until `mem_rvalid` has returned the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Write one stream descriptor |
| desc_idx | input | 3 | Descriptor index to write |
| desc_data | input | 64 | Descriptor contents (field layout in R2) |
| start | input | 1 | Begin a batch (one-cycle pulse) |
| shader_sel | input | 1 | Selects which destination offset applies |
| stream_mask | input | 8 | Per-stream enable, bit n enables stream n |
| vcnt_m1 | input | 4 | Number of vertices in the batch minus one |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| rd_row | input | 6 | Attribute memory read row |
| rd_col | input | 4 | Attribute memory read column (vertex) |
| rd_data | output | 32 | Registered read data |
| done | output | 1 | Batch complete pulse |
| err | output | 1 | Descriptor size error pulse |

## Verification
The bench builds the block with its default parameters: eight streams, sixteen-vertex batches and 64 attribute rows. These values make the last stream index, a full sixteen-column batch and a single-vertex batch all reachable. With the real 6-bit row width, an offset selected with the wrong shader bit lands on a different row, so the readback catches it. A scoreboard predicts every read address and every row/column word from the descriptors the bench loaded. Rows owned by disabled streams are read back again after later batches to confirm they are untouched.

// File: rtl/afe_pkg.sv
`timescale 1ns/1ps
package afe_pkg;
  // Descriptor word: fields packed MSB first, base address in the low 32 bits.
  typedef struct packed {
    logic [7:0]  off1;
    logic [7:0]  off0;
    logic [7:0]  stride;
    logic [7:0]  size_m1;
    logic [31:0] base;
  } stream_desc_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_REQ,
    S_WAIT,
    S_FIN
  } walk_state_t;
endpackage

// File: rtl/afe_desc_table.sv
`timescale 1ns/1ps
module afe_desc_table
  import afe_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  localparam int SIDX_W = $clog2(NUM_STREAMS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                we,
  input  logic [SIDX_W-1:0]                   idx,
  input  stream_desc_t                        wdata,
  output stream_desc_t [NUM_STREAMS-1:0]      desc_o,
  output logic [NUM_STREAMS-1:0]              bad_o
);
  stream_desc_t [NUM_STREAMS-1:0] tbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl <= '0;
    end else if (we) begin
      tbl[idx] <= wdata;
    end
  end

  // A per-vertex size that is not a whole number of words is invalid.
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_chk
    assign bad_o[g] = (tbl[g].size_m1[1:0] != 2'b11);
  end

  assign desc_o = tbl;
endmodule

// File: rtl/afe_attr_mem.sv
`timescale 1ns/1ps
module afe_attr_mem #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 4,
  parameter int DATA_W = 32,
  localparam int DEPTH = (1 << (ROW_W + COL_W))
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [COL_W-1:0]  wcol,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  rrow,
  input  logic [COL_W-1:0]  rcol,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port style: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[{wrow, wcol}] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[{rrow, rcol}];
  end

  p_wr_addr_known_r4: assert property (@(posedge clk)
    we |-> !$isunknown({wrow, wcol}));
endmodule

// File: rtl/afe_walker.sv
`timescale 1ns/1ps
module afe_walker
  import afe_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int COL_W       = 4,
  parameter int ROW_W       = 6,
  parameter int DATA_W      = 32,
  localparam int SIDX_W = $clog2(NUM_STREAMS),
  localparam int WIDX_W = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic                            sel,
  input  logic [NUM_STREAMS-1:0]          mask,
  input  logic [COL_W-1:0]                vcnt_m1,
  input  stream_desc_t [NUM_STREAMS-1:0]  desc,
  input  logic [NUM_STREAMS-1:0]          bad,
  output logic                            mem_req,
  output logic [31:0]                     mem_addr,
  input  logic                            mem_rvalid,
  input  logic [DATA_W-1:0]               mem_rdata,
  output logic                            wr_en,
  output logic [ROW_W-1:0]                wr_row,
  output logic [COL_W-1:0]                wr_col,
  output logic [DATA_W-1:0]               wr_data,
  output logic                            done,
  output logic                            err
);
  localparam logic [SIDX_W-1:0] LAST_S = SIDX_W'(NUM_STREAMS - 1);

  walk_state_t              state;
  logic [SIDX_W-1:0]        sidx;
  logic [COL_W-1:0]         vidx;
  logic [WIDX_W-1:0]        widx;
  logic [31:0]              vbase;
  logic [NUM_STREAMS-1:0]   mask_q;
  logic                     sel_q;
  logic [COL_W-1:0]         vcnt_q;

  stream_desc_t             cur;
  logic [WIDX_W-1:0]        last_w;
  logic [5:0]               row_base;
  logic [7:0]               row_sum;

  always_comb begin
    cur      = desc[sidx];
    last_w   = cur.size_m1[7:2];
    row_base = sel_q ? cur.off1[7:2] : cur.off0[7:2];
    row_sum  = {2'b00, row_base} + {2'b00, widx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      sidx     <= '0;
      vidx     <= '0;
      widx     <= '0;
      vbase    <= '0;
      mask_q   <= '0;
      sel_q    <= 1'b0;
      vcnt_q   <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      wr_en    <= 1'b0;
      wr_row   <= '0;
      wr_col   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      wr_en   <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            mask_q <= mask;
            sel_q  <= sel;
            vcnt_q <= vcnt_m1;
            if (|(bad & mask)) begin
              err <= 1'b1;
            end else begin
              sidx  <= '0;
              state <= S_PICK;
            end
          end
        end
        S_PICK: begin
          if (mask_q[sidx]) begin
            vidx  <= '0;
            widx  <= '0;
            vbase <= cur.base;
            state <= S_REQ;
          end else if (sidx == LAST_S) begin
            state <= S_FIN;
          end else begin
            sidx <= sidx + 1'b1;
          end
        end
        S_REQ: begin
          mem_req  <= 1'b1;
          mem_addr <= vbase + 32'({widx, 2'b00});
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rvalid) begin
            wr_en   <= 1'b1;
            wr_row  <= row_sum[ROW_W-1:0];
            wr_col  <= vidx;
            wr_data <= mem_rdata;
            if (widx == last_w) begin
              widx <= '0;
              if (vidx == vcnt_q) begin
                if (sidx == LAST_S) begin
                  state <= S_FIN;
                end else begin
                  sidx  <= sidx + 1'b1;
                  state <= S_PICK;
                end
              end else begin
                vidx  <= vidx + 1'b1;
                vbase <= vbase + 32'(cur.stride);
                state <= S_REQ;
              end
            end else begin
              widx  <= widx + 1'b1;
              state <= S_REQ;
            end
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: request is a single-cycle pulse
  p_req_single_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R10: nothing new while a read is outstanding
  p_no_req_pending_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !mem_rvalid) |=> !mem_req);

  // R4: a memory write is only made from returned read data
  p_wr_from_data_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(mem_rvalid));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: an error answers a start and never coincides with done
  p_err_after_start_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(start) && !done && !mem_req));
endmodule

// File: rtl/attr_stream_fetch.sv
`timescale 1ns/1ps
module attr_stream_fetch
  import afe_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int MAX_VERTS   = 16,
  parameter int ROW_W       = 6,
  parameter int DATA_W      = 32,
  localparam int SIDX_W = $clog2(NUM_STREAMS),
  localparam int COL_W  = $clog2(MAX_VERTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    desc_we,
  input  logic [SIDX_W-1:0]       desc_idx,
  input  logic [63:0]             desc_data,
  input  logic                    start,
  input  logic                    shader_sel,
  input  logic [NUM_STREAMS-1:0]  stream_mask,
  input  logic [COL_W-1:0]        vcnt_m1,
  output logic                    mem_req,
  output logic [31:0]             mem_addr,
  input  logic                    mem_rvalid,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic [ROW_W-1:0]        rd_row,
  input  logic [COL_W-1:0]        rd_col,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    done,
  output logic                    err
);
  stream_desc_t [NUM_STREAMS-1:0] desc;
  logic [NUM_STREAMS-1:0]         bad;
  logic                           wr_en;
  logic [ROW_W-1:0]               wr_row;
  logic [COL_W-1:0]               wr_col;
  logic [DATA_W-1:0]              wr_data;

  afe_desc_table #(.NUM_STREAMS(NUM_STREAMS)) u_desc (
    .clk    (clk),
    .rst    (rst),
    .we     (desc_we),
    .idx    (desc_idx),
    .wdata  (stream_desc_t'(desc_data)),
    .desc_o (desc),
    .bad_o  (bad)
  );

  afe_walker #(
    .NUM_STREAMS (NUM_STREAMS),
    .COL_W       (COL_W),
    .ROW_W       (ROW_W),
    .DATA_W      (DATA_W)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sel        (shader_sel),
    .mask       (stream_mask),
    .vcnt_m1    (vcnt_m1),
    .desc       (desc),
    .bad        (bad),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .wr_en      (wr_en),
    .wr_row     (wr_row),
    .wr_col     (wr_col),
    .wr_data    (wr_data),
    .done       (done),
    .err        (err)
  );

  afe_attr_mem #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .wrow  (wr_row),
    .wcol  (wr_col),
    .wdata (wr_data),
    .rrow  (rd_row),
    .rcol  (rd_col),
    .rdata (rd_data)
  );

  // R1: outputs quiet in the first cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && !err && !mem_req));
endmodule

// File: tb/test_attr_stream_fetch.sv
`timescale 1ns/1ps
module test_attr_stream_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_we = 1'b0;
  logic [2:0]  desc_idx = '0;
  logic [63:0] desc_data = '0;
  logic        start = 1'b0;
  logic        shader_sel = 1'b0;
  logic [7:0]  stream_mask = '0;
  logic [3:0]  vcnt_m1 = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [5:0]  rd_row = '0;
  logic [3:0]  rd_col = '0;
  logic [31:0] rd_data;
  logic        done;
  logic        err;

  always #4 clk = ~clk;

  attr_stream_fetch i_attr_stream_fetch (
    .clk(clk), .rst(rst), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_data(desc_data), .start(start), .shader_sel(shader_sel),
    .stream_mask(stream_mask), .vcnt_m1(vcnt_m1), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .done(done), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  logic [63:0] bd [8];
  logic [31:0] exp_addr [$];
  logic [41:0] exp_wr [$];
  logic [41:0] keep_wr [$];

  function automatic logic [31:0] dat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pulse counters
  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
    if (err) err_cnt++;
  end

  // Memory model plus address scoreboard
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      logic [31:0] a;
      a = mem_addr;
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R3/R6/R7 unexpected read", a, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_addr.pop_front();
        chk(a == e, "R2 read address/order", a, e);
      end
      @(negedge clk);
      chk(!mem_req, "R10 single request", {31'b0, mem_req}, 32'h0);
      @(negedge clk);
      mem_rvalid = 1'b1;
      mem_rdata  = dat(a);
      @(negedge clk);
      mem_rvalid = 1'b0;
    end
  end

  task automatic load(input int idx, input logic [31:0] base, input logic [7:0] szm1,
                      input logic [7:0] stride, input logic [7:0] o0, input logic [7:0] o1);
    @(negedge clk);
    bd[idx]   = {o1, o0, stride, szm1, base};
    desc_we   = 1'b1;
    desc_idx  = 3'(idx);
    desc_data = bd[idx];
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic plan(input logic [7:0] m, input logic sel, input int vm1);
    for (int s = 0; s < 8; s++) begin
      if (m[s]) begin
        int words;
        int rowb;
        words = (int'(bd[s][39:32]) + 1) / 4;
        rowb  = (sel ? int'(bd[s][63:56]) : int'(bd[s][55:48])) / 4;
        for (int v = 0; v <= vm1; v++) begin
          for (int w = 0; w < words; w++) begin
            logic [31:0] a;
            logic [5:0]  r;
            a = bd[s][31:0] + 32'(v * int'(bd[s][47:40])) + 32'(4 * w);
            r = 6'((rowb + w) % 64);
            exp_addr.push_back(a);
            exp_wr.push_back({r, 4'(v), dat(a)});
          end
        end
      end
    end
  endtask

  task automatic rd(input logic [5:0] r, input logic [3:0] c, output logic [31:0] d);
    @(negedge clk);
    rd_row = r;
    rd_col = c;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic verify_mem(input string req);
    logic [31:0] d;
    foreach (exp_wr[i]) begin
      rd(exp_wr[i][41:36], exp_wr[i][35:32], d);
      chk(d == exp_wr[i][31:0], req, d, exp_wr[i][31:0]);
    end
  endtask

  task automatic run(input logic [7:0] m, input logic sel, input int vm1,
                     input bit poke, input string req);
    int d0;
    int e0;
    int t;
    exp_wr.delete();
    plan(m, sel, vm1);
    d0 = done_cnt;
    e0 = err_cnt;
    @(negedge clk);
    start = 1'b1; stream_mask = m; shader_sel = sel; vcnt_m1 = 4'(vm1);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; stream_mask = 8'hFF; shader_sel = ~sel; vcnt_m1 = 4'd15;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1, {"R8 one done ", req}, 32'(done_cnt - d0), 32'd1);
    chk(err_cnt == e0, {"R7/R9 no err ", req}, 32'(err_cnt - e0), 32'd0);
    chk(exp_addr.size() == 0, {"R3 all reads issued ", req}, 32'(exp_addr.size()), 32'd0);
    exp_addr.delete();
    verify_mem({"R4 placement ", req});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int d0;
    int e0;
    repeat (3) @(negedge clk);
    chk(!done && !err && !mem_req, "R1 reset state", {29'b0, done, err, mem_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !err && !mem_req, "R1 after reset", {29'b0, done, err, mem_req}, 32'h0);

    load(0, 32'h0000_1000, 8'd11, 8'd12, 8'd0, 8'd0);
    load(1, 32'h0000_2000, 8'd27, 8'd28, 8'd0, 8'd16);
    load(2, 32'h0000_4000, 8'd5,  8'd8,  8'd0, 8'd0);
    load(3, 32'h0000_3000, 8'd7,  8'd20, 8'd48, 8'd0);
    load(5, 32'h0000_5004, 8'd3,  8'd4,  8'd32, 8'd0);
    load(7, 32'h0000_7000, 8'd3,  8'd16, 8'd60, 8'd0);

    // R2 R4 R9: one stream, four vertices, a second start mid-batch
    run(8'b0000_0001, 1'b0, 3, 1'b1, "stream0 x4 (R9 poke)");
    keep_wr = exp_wr;

    // R5 R6: shader-1 offsets, full sixteen vertices, stream 0 disabled
    run(8'b0000_0010, 1'b1, 15, 1'b0, "R5 stream1 x16 sel1");
    foreach (keep_wr[i]) begin
      rd(keep_wr[i][41:36], keep_wr[i][35:32], d);
      chk(d == keep_wr[i][31:0], "R6 disabled rows untouched", d, keep_wr[i][31:0]);
    end

    // R2 R7: stride larger than size, ascending streams, invalid stream 2 disabled
    run(8'b0010_1000, 1'b0, 2, 1'b0, "R2 gaps streams3,5");

    // R3 R5: two streams, single vertex, shader-1 offsets
    run(8'b0000_0011, 1'b1, 0, 1'b0, "R3 one vertex sel1");

    // Highest stream index, row wrap check not relied on (row 15)
    run(8'b1000_0000, 1'b0, 7, 1'b0, "stream7 x8");

    // R6: empty mask completes without reads
    run(8'b0000_0000, 1'b0, 5, 1'b0, "R6 empty mask");

    // R7: enabled invalid size
    d0 = done_cnt;
    e0 = err_cnt;
    @(negedge clk);
    start = 1'b1; stream_mask = 8'b0000_0101; shader_sel = 1'b0; vcnt_m1 = 4'd3;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R7 err in cycle after start", {31'b0, err}, 32'h1);
    repeat (40) @(negedge clk);
    chk(err_cnt == e0 + 1, "R7 single err pulse", 32'(err_cnt - e0), 32'd1);
    chk(done_cnt == d0, "R7 no done on error", 32'(done_cnt - d0), 32'd0);

    // Engine still usable after an error
    run(8'b0000_0001, 1'b0, 1, 1'b0, "R8 after error");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule